// File: doc/BRIEF.md
# Memory Channel Address Translator

This block turns a linear physical address into the coordinates of a memory system: which channel serves it and the bank, row, column and burst index inside that channel. It also returns a "high word" of upper address bits, which a downstream channel hash consumes. All configuration arrives on static inputs: one bit mask per field with low and high bit limits, the bit where the channel field starts, the channel count and the sub-partition count.

There are two modes. With a power-of-two channel count, every field is gathered directly from the address through its mask. An optional permutation can XOR low bits of the high word into the channel index, which spreads power-of-two strides across channels. With any other channel count, the address above the channel start bit is divided by the channel count. The remainder selects the channel. The quotient, stitched back above the untouched low bits, is the address the other fields are gathered from.

Requests use a valid/ready handshake. A power-of-two translation returns one cycle after acceptance. A divided translation uses an iterative divider that needs one cycle per address bit, and the block refuses new requests while it runs.

Top module: `chan_addr_xlate`

## Requirements
- R1: After reset `rsp_valid` is low and `req_ready` is high.
- R2: In power-of-two mode (`cfg_npow2`=0), each of bank, row, column, burst and channel is built from the address bits whose mask bit is 1 and whose position lies within [lo, hi] of that field. The lowest such position lands in bit 0 of the result and the others follow in ascending order. Field index order in the configuration arrays is channel=0, bank=1, row=2, column=3, burst=4. The response appears with `rsp_valid` on the cycle after acceptance.
- R3: In power-of-two mode, `rsp_high` equals the address shifted right by (channel start + log2 of channel count + log2 of sub-partition count).
- R4: In power-of-two mode with `cfg_permute`=1, `rsp_chip` equals the gathered channel field XOR (`rsp_high` AND (channel count − 1)).
- R5: In divided mode (`cfg_npow2`=1), `rsp_chip` equals (address >> channel start) modulo the channel count.
- R6: In divided mode, `rsp_high` equals (address >> channel start) divided by the channel count.
- R7: In divided mode, bank, row, column and burst are gathered as in R2. The source is (quotient << channel start) OR the address bits below the channel start.
- R8: In divided mode, `req_ready` is low and no response is given on the cycle after acceptance. The response arrives within ADDR_W+2 cycles of acceptance.
- R9: `rsp_err` is 1 exactly when `cfg_permute` and `cfg_npow2` are both set. In that case the permutation has no effect on `rsp_chip`.
- R10: Every response has `rsp_chip` below `cfg_n_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Linear address |
| cfg_npow2 | input | 1 | 1 selects the divided (non-power-of-two) mode |
| cfg_permute | input | 1 | 1 selects the XOR channel permutation |
| cfg_chip_start | input | IW | Lowest address bit of the channel field |
| cfg_n_chan | input | CH_W | Number of channels |
| cfg_n_sub | input | SUB_W | Sub-partitions per channel (power of two) |
| cfg_mask | input | 5 x ADDR_W | Per-field bit-select masks |
| cfg_lo | input | 5 x IW | Per-field lowest bit considered |
| cfg_hi | input | 5 x IW | Per-field highest bit considered |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_chip | output | CH_W | Channel index |
| rsp_bank | output | ADDR_W | Bank index |
| rsp_row | output | ADDR_W | Row index |
| rsp_col | output | ADDR_W | Column index |
| rsp_burst | output | ADDR_W | Burst index |
| rsp_high | output | ADDR_W | Upper address word for channel hashing |
| rsp_err | output | 1 | Permutation requested in divided mode |

## Verification
The main function is driven with all-zero, all-ones and mixed addresses, plus single-bit strides. Across these, the bench separates correct bit packing from shifted or reordered packing. The column mask holds bits above its high limit, so it shows whether the limits clip the gather. In divided mode with six channels, addresses just below and above a multiple of the count separate the remainder from the quotient and test the restitching of the low bits. Repeating the strides with the permutation on shows whether the high word is XORed into the channel, and in divided mode whether the permutation is blocked and flagged.

// File: rtl/chan_addr_pkg.sv
package chan_addr_pkg;

   localparam int NFLD = 5;

   typedef enum int unsigned {
      FLD_CHIP  = 0,
      FLD_BANK  = 1,
      FLD_ROW   = 2,
      FLD_COL   = 3,
      FLD_BURST = 4
   } fld_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } xl_state_e;

endpackage

// File: rtl/chan_bit_gather.sv
module chan_bit_gather #(
   parameter int W  = 32,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [W-1:0]  mask,
   input  logic [IW-1:0] lo,
   input  logic [IW-1:0] hi,
   output logic [W-1:0]  dout
);

   localparam int KW = $clog2(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("chan_bit_gather: W must be at least 2");
      end
   endgenerate

   // slot is the next free output position; selected bits pack upward
   logic [KW-1:0] slot;

   always_comb begin
      dout = '0;
      slot = '0;
      for (int i = 0; i < W; i++) begin
         if (mask[i] && (IW'(i) >= lo) && (IW'(i) <= hi)) begin
            dout[slot] = din[i];
            slot       = slot + 1'b1;
         end
      end
   end

endmodule

// File: rtl/chan_iter_div.sv
module chan_iter_div #(
   parameter int DW = 32,
   parameter int VW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] dividend,
   input  logic [VW-1:0] divisor,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quo,
   output logic [VW-1:0] rem
);

   localparam int CNT_W = $clog2(DW + 1);

   generate
      if (VW >= DW) begin : g_bad_vw
         $error("chan_iter_div: divisor must be narrower than dividend");
      end
   endgenerate

   logic [DW-1:0]    acc_q;
   logic [VW-1:0]    rem_q;
   logic [VW-1:0]    div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   // one restoring step: bring the next dividend bit into the remainder
   logic [VW:0] trial;
   logic [VW:0] diff;
   logic        fits;

   always_comb begin
      trial = {rem_q, acc_q[DW-1]};
      diff  = trial - {1'b0, div_q};
      fits  = (trial >= {1'b0, div_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rem_q  <= '0;
         div_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            acc_q  <= dividend;
            rem_q  <= '0;
            div_q  <= divisor;
            cnt_q  <= CNT_W'(DW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            acc_q <= {acc_q[DW-2:0], fits};
            rem_q <= fits ? diff[VW-1:0] : trial[VW-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign quo  = acc_q;
   assign rem  = rem_q;

   // R5: the final remainder is below the divisor
   p_rem_below_div_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem < div_q));

   // R8: completion only follows an active run
   p_done_after_run_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy_q));

endmodule

// File: rtl/chan_addr_xlate.sv
module chan_addr_xlate
   import chan_addr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CH_W   = 6,
   parameter int SUB_W  = 3,
   localparam int IW    = $clog2(ADDR_W)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic                         cfg_npow2,
   input  logic                         cfg_permute,
   input  logic [IW-1:0]                cfg_chip_start,
   input  logic [CH_W-1:0]              cfg_n_chan,
   input  logic [SUB_W-1:0]             cfg_n_sub,
   input  logic [NFLD-1:0][ADDR_W-1:0]  cfg_mask,
   input  logic [NFLD-1:0][IW-1:0]      cfg_lo,
   input  logic [NFLD-1:0][IW-1:0]      cfg_hi,
   output logic                         rsp_valid,
   output logic [CH_W-1:0]              rsp_chip,
   output logic [ADDR_W-1:0]            rsp_bank,
   output logic [ADDR_W-1:0]            rsp_row,
   output logic [ADDR_W-1:0]            rsp_col,
   output logic [ADDR_W-1:0]            rsp_burst,
   output logic [ADDR_W-1:0]            rsp_high,
   output logic                         rsp_err
);

   localparam int SH_W  = IW + 2;
   localparam int BC_W  = $clog2(ADDR_W + 3);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("chan_addr_xlate: ADDR_W must be at least 8");
      end
      if (CH_W >= ADDR_W) begin : g_bad_ch
         $error("chan_addr_xlate: CH_W must be narrower than ADDR_W");
      end
      if (SUB_W < 1) begin : g_bad_sub
         $error("chan_addr_xlate: SUB_W must be at least 1");
      end
   endgenerate

   // ---------------- handshake and mode state ----------------
   xl_state_e st_q;
   logic      accept;
   logic      div_start;
   logic      div_busy;
   logic      div_done;
   logic      load;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && (st_q == ST_IDLE);
   assign div_start = accept && cfg_npow2;

   // ---------------- configuration-derived log2 values ----------------
   logic [IW-1:0] l2_chan;
   logic [IW-1:0] l2_sub;

   always_comb begin
      l2_chan = '0;
      for (int i = 0; i < CH_W; i++) begin
         if (cfg_n_chan[i]) l2_chan = IW'(i);
      end
   end

   always_comb begin
      l2_sub = '0;
      for (int i = 0; i < SUB_W; i++) begin
         if (cfg_n_sub[i]) l2_sub = IW'(i);
      end
   end

   // ---------------- divided path ----------------
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] div_quo;
   logic [CH_W-1:0]   div_rem;
   logic [ADDR_W-1:0] low_keep;
   logic [ADDR_W-1:0] rest_addr;

   chan_iter_div #(
      .DW (ADDR_W),
      .VW (CH_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (div_start),
      .dividend (req_addr >> cfg_chip_start),
      .divisor  (cfg_n_chan),
      .busy     (div_busy),
      .done     (div_done),
      .quo      (div_quo),
      .rem      (div_rem)
   );

   assign low_keep  = ~({ADDR_W{1'b1}} << cfg_chip_start);
   assign rest_addr = (div_quo << cfg_chip_start) | (addr_q & low_keep);

   // ---------------- field gathering ----------------
   logic [ADDR_W-1:0]            src_addr;
   logic [NFLD-1:0][ADDR_W-1:0]  fld;

   assign src_addr = (st_q == ST_BUSY) ? rest_addr : req_addr;

   generate
      for (genvar f = 0; f < NFLD; f++) begin : g_fld
         chan_bit_gather #(
            .W  (ADDR_W),
            .IW (IW)
         ) u_gather (
            .din  (src_addr),
            .mask (cfg_mask[f]),
            .lo   (cfg_lo[f]),
            .hi   (cfg_hi[f]),
            .dout (fld[f])
         );
      end
   endgenerate

   // ---------------- power-of-two channel and high word ----------------
   logic [SH_W-1:0]   high_shift;
   logic [ADDR_W-1:0] high_p2;
   logic [CH_W-1:0]   chan_lim;
   logic [CH_W-1:0]   perm_term;
   logic [CH_W-1:0]   chip_p2;
   logic              unused_chip_top;

   assign high_shift = {2'b00, cfg_chip_start} + {2'b00, l2_chan} + {2'b00, l2_sub};
   assign high_p2    = req_addr >> high_shift;
   assign chan_lim   = cfg_n_chan - 1'b1;
   assign perm_term  = cfg_permute ? (high_p2[CH_W-1:0] & chan_lim) : '0;
   assign chip_p2    = fld[FLD_CHIP][CH_W-1:0] ^ perm_term;
   assign unused_chip_top = ^fld[FLD_CHIP][ADDR_W-1:CH_W];

   // ---------------- result register ----------------
   assign load = (accept && !cfg_npow2) || ((st_q == ST_BUSY) && div_done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_chip  <= '0;
         rsp_bank  <= '0;
         rsp_row   <= '0;
         rsp_col   <= '0;
         rsp_burst <= '0;
         rsp_high  <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= load;
         if (accept) addr_q <= req_addr;
         case (st_q)
            ST_IDLE: if (div_start) st_q <= ST_BUSY;
            ST_BUSY: if (div_done)  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
         if (load) begin
            rsp_bank  <= fld[FLD_BANK];
            rsp_row   <= fld[FLD_ROW];
            rsp_col   <= fld[FLD_COL];
            rsp_burst <= fld[FLD_BURST];
            if (st_q == ST_BUSY) begin
               rsp_chip <= div_rem;
               rsp_high <= div_quo;
               rsp_err  <= cfg_permute;
            end else begin
               rsp_chip <= chip_p2;
               rsp_high <= high_p2;
               rsp_err  <= 1'b0;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   logic [BC_W-1:0] busy_cyc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_cyc_q <= '0;
      else if (st_q == ST_BUSY) busy_cyc_q <= busy_cyc_q + 1'b1;
      else busy_cyc_q <= '0;
   end

   // R2: power-of-two translations answer on the next cycle
   p_pow2_next_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cfg_npow2) |=> rsp_valid);

   // R8: a divided request gives no answer on the next cycle
   p_div_not_next_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cfg_npow2) |=> !rsp_valid);

   // R8: no new request is taken while the divider runs
   p_ready_low_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !req_ready);

   // R8: the divided path finishes within its bound
   p_div_bound_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BUSY) |-> (busy_cyc_q <= BC_W'(ADDR_W + 1)));

   // R9: the error flag only appears in the illegal combination
   p_err_mode_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (cfg_npow2 && cfg_permute));

   // R10: the channel index stays inside the configured count
   p_chip_range_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_chip < cfg_n_chan));

endmodule

// File: tb/chan_addr_xlate_test.sv
module chan_addr_xlate_test;
   import chan_addr_pkg::*;

   localparam int AW = 32;
   localparam int CW = 6;
   localparam int SW = 3;
   localparam int IW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                    req_valid = 1'b0;
   logic                    req_ready;
   logic [AW-1:0]           req_addr = '0;
   logic                    cfg_npow2 = 1'b0;
   logic                    cfg_permute = 1'b0;
   logic [IW-1:0]           cfg_chip_start = 5'd8;
   logic [CW-1:0]           cfg_n_chan = 6'd8;
   logic [SW-1:0]           cfg_n_sub = 3'd2;
   logic [NFLD-1:0][AW-1:0] cfg_mask;
   logic [NFLD-1:0][IW-1:0] cfg_lo;
   logic [NFLD-1:0][IW-1:0] cfg_hi;
   logic                    rsp_valid;
   logic [CW-1:0]           rsp_chip;
   logic [AW-1:0]           rsp_bank, rsp_row, rsp_col, rsp_burst, rsp_high;
   logic                    rsp_err;

   chan_addr_xlate #(.ADDR_W(AW), .CH_W(CW), .SUB_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .cfg_npow2(cfg_npow2), .cfg_permute(cfg_permute),
      .cfg_chip_start(cfg_chip_start), .cfg_n_chan(cfg_n_chan), .cfg_n_sub(cfg_n_sub),
      .cfg_mask(cfg_mask), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .rsp_valid(rsp_valid), .rsp_chip(rsp_chip), .rsp_bank(rsp_bank),
      .rsp_row(rsp_row), .rsp_col(rsp_col), .rsp_burst(rsp_burst),
      .rsp_high(rsp_high), .rsp_err(rsp_err)
   );

   typedef struct packed {
      logic          npow2;
      logic          perm;
      logic [CW-1:0] chip;
      logic [AW-1:0] bank;
      logic [AW-1:0] row;
      logic [AW-1:0] col;
      logic [AW-1:0] burst;
      logic [AW-1:0] high;
      logic          err;
   } exp_t;

   exp_t sbq[$];
   int   checks = 0;
   int   failures = 0;
   int   sent = 0;
   int   seen = 0;
   bit   finished = 1'b0;

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] tb_gather(input logic [AW-1:0] a, input logic [AW-1:0] m,
                                               input int lo, input int hi);
      int n = 0;
      logic [AW-1:0] r = '0;
      for (int b = lo; b <= hi; b++) begin
         if (m[b]) begin
            r[n] = a[b];
            n++;
         end
      end
      return r;
   endfunction

   function automatic exp_t model(input logic [AW-1:0] a);
      exp_t e;
      logic [AW-1:0] src, sh, q;
      int cs = int'(cfg_chip_start);
      int n  = int'(cfg_n_chan);
      e.npow2 = cfg_npow2;
      e.perm  = cfg_permute;
      if (!cfg_npow2) begin
         src    = a;
         e.high = a >> (cs + $clog2(n) + $clog2(int'(cfg_n_sub)));
         e.chip = CW'(tb_gather(a, cfg_mask[0], cfg_lo[0], cfg_hi[0]));
         if (cfg_permute) e.chip = e.chip ^ (CW'(e.high) & CW'(n - 1));
         e.err  = 1'b0;
      end else begin
         sh     = a >> cs;
         q      = sh / AW'(n);
         e.chip = CW'(sh % AW'(n));
         e.high = q;
         src    = (q << cs) | (a & ((AW'(1) << cs) - 1));
         e.err  = cfg_permute;
      end
      e.bank  = tb_gather(src, cfg_mask[1], cfg_lo[1], cfg_hi[1]);
      e.row   = tb_gather(src, cfg_mask[2], cfg_lo[2], cfg_hi[2]);
      e.col   = tb_gather(src, cfg_mask[3], cfg_lo[3], cfg_hi[3]);
      e.burst = tb_gather(src, cfg_mask[4], cfg_lo[4], cfg_hi[4]);
      return e;
   endfunction

   // driver: push the expected item, then hand the request over
   task automatic send(input logic [AW-1:0] a);
      sbq.push_back(model(a));
      sent++;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (cfg_npow2) begin
         chk("R8 ready low after divided accept", AW'(req_ready), AW'(0));
         chk("R8 no response on next cycle", AW'(rsp_valid), AW'(0));
      end
   endtask

   task automatic drain;
      while (sbq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pop and compare each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         seen++;
         if (sbq.size() == 0) begin
            chk("R2 unexpected response", AW'(1), AW'(0));
         end else begin
            e = sbq.pop_front();
            if (e.npow2) begin
               chk("R5 chip modulo", AW'(rsp_chip), AW'(e.chip));
               chk("R6 high quotient", rsp_high, e.high);
               chk("R7 bank", rsp_bank, e.bank);
               chk("R7 row", rsp_row, e.row);
               chk("R7 col", rsp_col, e.col);
               chk("R7 burst", rsp_burst, e.burst);
            end else begin
               chk(e.perm ? "R4 permuted chip" : "R2 chip", AW'(rsp_chip), AW'(e.chip));
               chk("R3 high word", rsp_high, e.high);
               chk("R2 bank", rsp_bank, e.bank);
               chk("R2 row", rsp_row, e.row);
               chk("R2 col limits", rsp_col, e.col);
               chk("R2 burst", rsp_burst, e.burst);
            end
            chk("R9 error flag", AW'(rsp_err), AW'(e.err));
            chk("R10 chip in range", AW'(rsp_chip < cfg_n_chan), AW'(1));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cfg_mask[0] = 32'h0000_0700; cfg_lo[0] = 5'd8;  cfg_hi[0] = 5'd10;
      cfg_mask[1] = 32'h0007_8000; cfg_lo[1] = 5'd15; cfg_hi[1] = 5'd18;
      cfg_mask[2] = 32'hFFF8_0000; cfg_lo[2] = 5'd19; cfg_hi[2] = 5'd31;
      cfg_mask[3] = 32'h0000_78E0; cfg_lo[3] = 5'd5;  cfg_hi[3] = 5'd12;
      cfg_mask[4] = 32'h0000_001F; cfg_lo[4] = 5'd0;  cfg_hi[4] = 5'd4;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset valid", AW'(rsp_valid), AW'(0));
      chk("R1 reset ready", AW'(req_ready), AW'(1));

      // power-of-two, plain
      send(32'h0000_0000);
      send(32'hFFFF_FFFF);
      send(32'h1234_5678);
      send(32'hDEAD_BEEF);
      for (int k = 8; k < 24; k += 3) send(AW'(1) << k);
      drain();

      // power-of-two, permuted
      cfg_permute = 1'b1;
      for (int k = 10; k < 22; k++) send(AW'(1) << k);
      send(32'hCAFE_F00D);
      drain();

      // divided mode with six channels
      cfg_permute = 1'b0;
      cfg_npow2   = 1'b1;
      cfg_n_chan  = 6'd6;
      send(32'h0000_0000);
      send(32'h0000_05FF);
      send(32'h0000_0600);
      send(32'h1234_5678);
      send(32'hFFFF_FFFF);
      send(32'hABCD_EF01);
      drain();

      // divided mode with permutation requested: flagged, no effect
      cfg_permute = 1'b1;
      send(32'h0000_0700);
      send(32'h1234_5678);
      drain();

      chk("R2 response count", AW'(seen), AW'(sent));
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule